// File: doc/BRIEF.md
# Quad-SPI command transmitter

This block is a transmit-only serial master for flash or display controllers that accept a quad-capable serial link. On a start strobe it captures a command byte, a 24-bit address, a transfer mode, a byte count and an idle chip-select level. It then drives chip select, a serial clock at half the system clock rate and a 4-bit data bus through up to three phases: command, address and payload. The payload goes out on one line or on all four.

Payload bytes come from a wide parallel buffer input arranged as 32-bit words. The caller fills the buffer, sets the configuration inputs and pulses start while the block reports ready. A one-cycle done pulse marks the end of the frame, and ready returns in the next cycle. Because the resting level of chip select is programmable, several frames can be chained under one continuous select.

Top module: `qspi_cmd_tx`

## Requirements
- R1: While reset is held and in the first cycle after it is released, cs_n is 1, sck is 0, dq is 0, ready is 1 and done is 0.
- R2: While idle, cs_n follows idle_cs_lvl one cycle later (1 = deselected, 0 = held selected), and sck stays 0 whenever cs_n is 1 or the block is idle.
- R3: A start sampled while ready is 1 drives cs_n to 0 in the next cycle with sck still 0. After that sck toggles every system clock (rate clk/2), with the first rising edge one cycle later.
- R4: tx_mode encoding: 00 = command only, 01 = command + address, 10 = command + address + single-line payload, 11 = command + address + quad payload. The 8-bit command is sent first, MSB first, one bit per sck period on dq[0], with dq[3:1] = 0.
- R5: In modes 01, 10 and 11, the 24-bit address follows the command, MSB first on dq[0] with dq[3:1] = 0.
- R6: In mode 10, tx_len payload bytes follow the address, each MSB first on dq[0] with dq[3:1] = 0, one bit per sck period.
- R7: In mode 11, each sck period carries one nibble, the high nibble of a byte first, with nibble bit 3 on dq[3] and bit 0 on dq[0].
- R8: Payload byte k is taken from 32-bit word k/4 of payload (word w = payload[32w+31:32w]), and within the word byte k%4 = 0 is bits 31:24, down to k%4 = 3 at bits 7:0. Bytes with k at or beyond BUF_BYTES are sent as 0x00.
- R9: dq changes only in the cycle in which sck falls (or at frame start), so it is stable across every rising sck edge.
- R10: A tx_len of zero in mode 10 or 11 produces only the command and address (32 sck periods).
- R11: For a frame of U sck periods accepted at edge E0, done is high for exactly one cycle following edge E0+2U. In that cycle ready is 0 and cs_n equals the idle_cs_lvl captured at start. ready is 1 in the following cycle.
- R12: A start while ready is 0, including the done cycle, is ignored: the frame in progress and its data are unchanged, and no new frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch strobe, honoured only while ready |
| tx_mode | input | 2 | Phase set selection, captured at start |
| tx_cmd | input | 8 | Command byte, captured at start |
| tx_addr | input | 24 | Address, captured at start |
| tx_len | input | LEN_W | Payload byte count, captured at start |
| idle_cs_lvl | input | 1 | Resting level for cs_n when idle |
| payload | input | BUF_BYTES*8 | Payload buffer, 32-bit words, byte 0 in the top lane of word 0; held stable during a frame |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| dq | output | 4 | Serial data lines |
| ready | output | 1 | High while a start can be accepted |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Every result has a fixed delay from the start strobe. cs_n falls one cycle after start is accepted. Each sck period takes two cycles, so done for a U-period frame appears 2U+1 cycles after start is driven, and ready appears one cycle after that. The bench drives inputs on falling clock edges and samples at the next falling edge. It counts those samples from the start strobe and compares the count with 2U+1 worked out from the mode and length. Data is captured at each sample where sck is high and compared in order with the unit the requirements predict.

// File: rtl/qspi_tx_pkg.sv
// Shared constants and types for the quad-SPI command transmitter.
// Assumes a fixed 8-bit command and 24-bit address header.
package qspi_tx_pkg;
    localparam int CMD_BITS = 8;
    localparam int ADR_BITS = 24;
    localparam int HDR_BITS = CMD_BITS + ADR_BITS;

    localparam logic [1:0] MD_CMD_ONLY = 2'b00;
    localparam logic [1:0] MD_CMD_ADR  = 2'b01;
    localparam logic [1:0] MD_SERIAL   = 2'b10;
    localparam logic [1:0] MD_QUAD     = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } tx_state_t;
endpackage

// File: rtl/qspi_sck_gen.sv
// Serial clock generator: toggles sck every system clock while run is
// high, otherwise holds it low. fall_now marks the edge where sck drops.
// Assumes run is registered state from the sequencer.
module qspi_sck_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic fall_now
);
    // Half-rate toggle, parked low when not running
    always_ff @(posedge clk) begin
        if (!rst_n)   sck <= 1'b0;
        else if (run) sck <= ~sck;
        else          sck <= 1'b0;
    end

    // The coming edge takes sck from high to low
    always_comb fall_now = run && sck;
endmodule

// File: rtl/qspi_byte_pick.sv
// Payload byte selector: returns byte idx of a buffer laid out as 32-bit
// words, most significant lane first. Indices past the buffer give 0.
// Assumes BUF_BYTES is a multiple of 4 and fits in IDX_W bits.
module qspi_byte_pick #(
    parameter int BUF_BYTES = 64,
    parameter int IDX_W     = 11
) (
    input  logic [BUF_BYTES*8-1:0] buf_flat,
    input  logic [IDX_W-1:0]       idx,
    output logic [7:0]             byte_o
);
    localparam int SEL_W = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;

    logic [7:0] lanes [BUF_BYTES];

    generate
        for (genvar k = 0; k < BUF_BYTES; k++) begin : g_lane
            localparam int WORD = k / 4;
            localparam int LANE = 3 - (k % 4);
            assign lanes[k] = buf_flat[WORD*32 + LANE*8 +: 8];
        end
    endgenerate

    // Range-checked byte mux
    always_comb begin
        if ({1'b0, idx} < (IDX_W+1)'(BUF_BYTES))
            byte_o = lanes[idx[SEL_W-1:0]];
        else
            byte_o = 8'h00;
    end
endmodule

// File: rtl/qspi_tx_seq.sv
// Frame sequencer: captures configuration at start, walks the header and
// payload units, drives cs_n and dq, and reports ready/done.
// Assumes fall_now comes from qspi_sck_gen and pick_byte is the byte
// addressed by pick_idx in the same cycle.
module qspi_tx_seq
    import qspi_tx_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          mode_in,
    input  logic [CMD_BITS-1:0] cmd_in,
    input  logic [ADR_BITS-1:0] adr_in,
    input  logic [LEN_W-1:0]    len_in,
    input  logic                cs_idle_lvl,
    input  logic                fall_now,
    input  logic [7:0]          pick_byte,
    output logic [LEN_W-1:0]    pick_idx,
    output logic                run,
    output logic                cs_n,
    output logic [3:0]          dq,
    output logic                ready,
    output logic                done
);
    localparam int UC_W = $clog2(HDR_BITS);

    tx_state_t             st;
    logic                  in_data;
    logic [UC_W-1:0]       ucnt;
    logic [2:0]            dcnt;
    logic [LEN_W-1:0]      bidx;
    logic [HDR_BITS-1:0]   hdr_q;
    logic [1:0]            mode_q;
    logic [LEN_W-1:0]      len_q;
    logic                  csl_q;

    logic                  accept;
    logic [HDR_BITS-1:0]   hdr_src;
    logic [1:0]            mode_src;
    logic [LEN_W-1:0]      len_src;
    logic                  has_data, quad;
    logic [UC_W-1:0]       hdr_last;
    logic [2:0]            dlast;
    logic                  n_data, finish;
    logic [UC_W-1:0]       n_ucnt;
    logic [2:0]            n_dcnt;
    logic [LEN_W-1:0]      n_bidx;
    logic [3:0]            unit_bits;

    // Configuration source: live inputs when accepting, captured copy after
    always_comb begin
        accept   = (st == ST_IDLE) && start;
        hdr_src  = accept ? {cmd_in, adr_in} : hdr_q;
        mode_src = accept ? mode_in : mode_q;
        len_src  = accept ? len_in : len_q;
        has_data = mode_src[1] && (len_src != '0);
        quad     = (mode_src == MD_QUAD);
        hdr_last = (mode_src == MD_CMD_ONLY) ? UC_W'(CMD_BITS - 1) : UC_W'(HDR_BITS - 1);
        dlast    = quad ? 3'd1 : 3'd7;
    end

    // Next unit indices for a frame start or a falling sck edge
    always_comb begin
        n_data = in_data;
        n_ucnt = ucnt;
        n_dcnt = dcnt;
        n_bidx = bidx;
        finish = 1'b0;
        if (accept) begin
            n_data = 1'b0;
            n_ucnt = '0;
            n_dcnt = '0;
            n_bidx = '0;
        end else if (st == ST_SHIFT && fall_now) begin
            if (!in_data) begin
                if (ucnt == hdr_last) begin
                    if (has_data) begin
                        n_data = 1'b1;
                        n_dcnt = '0;
                        n_bidx = '0;
                    end else begin
                        finish = 1'b1;
                    end
                end else begin
                    n_ucnt = ucnt + 1'b1;
                end
            end else if (dcnt == dlast) begin
                if (bidx == len_q - LEN_W'(1)) begin
                    finish = 1'b1;
                end else begin
                    n_bidx = bidx + 1'b1;
                    n_dcnt = '0;
                end
            end else begin
                n_dcnt = dcnt + 1'b1;
            end
        end
    end

    assign pick_idx = n_bidx;

    // Line values for the unit about to be presented
    always_comb begin
        if (!n_data)
            unit_bits = {3'b000, hdr_src[UC_W'(HDR_BITS - 1) - n_ucnt]};
        else if (quad)
            unit_bits = n_dcnt[0] ? pick_byte[3:0] : pick_byte[7:4];
        else
            unit_bits = {3'b000, pick_byte[3'd7 - n_dcnt]};
    end

    // Frame state, captured configuration and line drivers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            in_data <= 1'b0;
            ucnt    <= '0;
            dcnt    <= '0;
            bidx    <= '0;
            hdr_q   <= '0;
            mode_q  <= MD_CMD_ONLY;
            len_q   <= '0;
            csl_q   <= 1'b1;
            cs_n    <= 1'b1;
            dq      <= 4'h0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        st      <= ST_SHIFT;
                        hdr_q   <= {cmd_in, adr_in};
                        mode_q  <= mode_in;
                        len_q   <= len_in;
                        csl_q   <= cs_idle_lvl;
                        cs_n    <= 1'b0;
                        dq      <= unit_bits;
                        in_data <= n_data;
                        ucnt    <= n_ucnt;
                        dcnt    <= n_dcnt;
                        bidx    <= n_bidx;
                    end else begin
                        cs_n <= cs_idle_lvl;
                    end
                end
                ST_SHIFT: begin
                    if (fall_now) begin
                        if (finish) begin
                            st   <= ST_DONE;
                            cs_n <= csl_q;
                            dq   <= 4'h0;
                        end else begin
                            dq      <= unit_bits;
                            in_data <= n_data;
                            ucnt    <= n_ucnt;
                            dcnt    <= n_dcnt;
                            bidx    <= n_bidx;
                        end
                    end
                end
                default: begin
                    st   <= ST_IDLE;
                    cs_n <= cs_idle_lvl;
                end
            endcase
        end
    end

    // Status decoded from the frame state
    always_comb begin
        run   = (st == ST_SHIFT);
        ready = (st == ST_IDLE);
        done  = (st == ST_DONE);
    end
endmodule

// File: rtl/qspi_cmd_tx.sv
// Quad-SPI command transmitter top: ties the sequencer, serial clock
// generator and payload byte selector together.
// Assumes payload is held stable for the length of a frame.
module qspi_cmd_tx
    import qspi_tx_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int LEN_W     = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [1:0]             tx_mode,
    input  logic [CMD_BITS-1:0]    tx_cmd,
    input  logic [ADR_BITS-1:0]    tx_addr,
    input  logic [LEN_W-1:0]       tx_len,
    input  logic                   idle_cs_lvl,
    input  logic [BUF_BYTES*8-1:0] payload,
    output logic                   cs_n,
    output logic                   sck,
    output logic [3:0]             dq,
    output logic                   ready,
    output logic                   done
);
    logic             run;
    logic             fall_now;
    logic [LEN_W-1:0] pick_idx;
    logic [7:0]       pick_byte;

    qspi_sck_gen u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sck      (sck),
        .fall_now (fall_now)
    );

    qspi_byte_pick #(.BUF_BYTES(BUF_BYTES), .IDX_W(LEN_W)) u_pick (
        .buf_flat (payload),
        .idx      (pick_idx),
        .byte_o   (pick_byte)
    );

    qspi_tx_seq #(.LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode_in     (tx_mode),
        .cmd_in      (tx_cmd),
        .adr_in      (tx_addr),
        .len_in      (tx_len),
        .cs_idle_lvl (idle_cs_lvl),
        .fall_now    (fall_now),
        .pick_byte   (pick_byte),
        .pick_idx    (pick_idx),
        .run         (run),
        .cs_n        (cs_n),
        .dq          (dq),
        .ready       (ready),
        .done        (done)
    );
endmodule

// File: rtl/qspi_cmd_tx_chk.sv
// Protocol checker for qspi_cmd_tx, attached by bind. Watches the ports
// only. Assumes synchronous active-low reset.
module qspi_cmd_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       cs_n,
    input logic       sck,
    input logic [3:0] dq,
    input logic       ready,
    input logic       done
);
    // R2: no serial clock while deselected
    assert_sck_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R9: data holds across each rising serial clock
    assert_edge_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(dq));

    // R11: done lasts one cycle and is followed by ready
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready));

    // R11: ready only comes back through done
    assert_ready_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(done));

    // R11: done follows the last high serial clock phase
    assert_last_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(sck));

    // R12: a start during a frame does not end it early
    assert_busy_ignores_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !done && start) |=> !ready);
endmodule

bind qspi_cmd_tx qspi_cmd_tx_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .cs_n  (cs_n),
    .sck   (sck),
    .dq    (dq),
    .ready (ready),
    .done  (done)
);

// File: tb/qspi_cmd_tx_test.sv
`timescale 1ns/1ps
module qspi_cmd_tx_test;
    localparam int BUF_BYTES = 64;
    localparam int LEN_W     = 11;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   start;
    logic [1:0]             tx_mode;
    logic [7:0]             tx_cmd;
    logic [23:0]            tx_addr;
    logic [LEN_W-1:0]       tx_len;
    logic                   idle_cs_lvl;
    logic [BUF_BYTES*8-1:0] payload;
    logic                   cs_n, sck, ready, done;
    logic [3:0]             dq;

    int total = 0;
    int bad   = 0;

    logic [31:0]            e_hdr;
    logic [1:0]             e_mode;
    int                     e_len;
    logic [BUF_BYTES*8-1:0] e_pay;

    always #2.5 clk = ~clk;

    qspi_cmd_tx #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_mode(tx_mode),
        .tx_cmd(tx_cmd), .tx_addr(tx_addr), .tx_len(tx_len),
        .idle_cs_lvl(idle_cs_lvl), .payload(payload), .cs_n(cs_n),
        .sck(sck), .dq(dq), .ready(ready), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int units(input logic [1:0] m, input int n);
        case (m)
            2'b00:   return 8;
            2'b01:   return 32;
            2'b10:   return 32 + 8 * n;
            default: return 32 + 2 * n;
        endcase
    endfunction

    function automatic logic [7:0] exp_byte(input int k);
        if (k >= BUF_BYTES) return 8'h00;
        return e_pay[(k / 4) * 32 + (3 - k % 4) * 8 +: 8];
    endfunction

    function automatic logic [3:0] exp_unit(input int i);
        int h;
        int d;
        logic [7:0] b;
        h = (e_mode == 2'b00) ? 8 : 32;
        if (i < h) return {3'b000, e_hdr[31 - i]};
        d = i - h;
        if (e_mode == 2'b11) begin
            b = exp_byte(d / 2);
            return (d % 2 == 0) ? b[7:4] : b[3:0];
        end
        b = exp_byte(d / 8);
        return {3'b000, b[7 - d % 8]};
    endfunction

    // One frame: drive start, capture units at sck-high samples, check timing
    task automatic run_xfer(input logic [1:0] m, input int n, input bit csl,
                            input bit poke, input string tag);
        int cnt;
        int idx;
        int ubad;
        int uact;
        int uexp;
        int stab;
        int u;
        logic [3:0] pdq;
        logic psck;
        tx_mode = m;
        tx_len  = LEN_W'(n);
        tx_cmd  = 8'($urandom);
        tx_addr = 24'($urandom);
        for (int w = 0; w < BUF_BYTES / 4; w++) payload[w * 32 +: 32] = $urandom;
        idle_cs_lvl = csl;
        e_hdr = {tx_cmd, tx_addr}; e_mode = m; e_len = n; e_pay = payload;
        u = units(m, n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        check(cs_n == 1'b0 && sck == 1'b0 && ready == 1'b0, "R3", {cs_n, sck, ready}, 0);
        idx = 0; ubad = -1; uact = 0; uexp = 0; stab = 0;
        pdq = dq; psck = sck;
        while (!done && cnt < 40000) begin
            @(negedge clk);
            cnt++;
            if (poke && cnt == 9) begin
                start = 1'b1; tx_cmd = ~tx_cmd; tx_mode = ~m; tx_len = '0;
            end
            if (poke && cnt == 10) start = 1'b0;
            if (sck && !cs_n) begin
                if (idx < u && dq !== exp_unit(idx) && ubad < 0) begin
                    ubad = idx; uact = int'(dq); uexp = int'(exp_unit(idx));
                end
                idx++;
            end
            if (sck && !psck && dq !== pdq) stab++;
            pdq = dq; psck = sck;
        end
        check(cnt == 2 * u + 1, tag, cnt, 2 * u + 1);
        check(idx == u, tag, idx, u);
        check(ubad < 0, tag, uact, uexp);
        check(stab == 0, "R9", stab, 0);
        check(done == 1'b1 && ready == 1'b0 && cs_n == csl, "R11",
              {done, ready, cs_n}, {2'b10, csl});
        if (poke) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ready == 1'b1 && done == 1'b0 && cs_n == csl && sck == 1'b0,
              poke ? "R12" : "R11", {ready, done, cs_n, sck}, {2'b10, csl, 1'b0});
        if (poke) begin
            @(negedge clk);
            check(ready == 1'b1 && sck == 1'b0, "R12", {ready, sck}, 2'b10);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; start = 1'b0; tx_mode = 2'b00; tx_cmd = '0; tx_addr = '0;
        tx_len = '0; idle_cs_lvl = 1'b1; payload = '0;
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && sck == 1'b0 && dq == 4'h0, "R1", {cs_n, sck, dq}, 6'b100000);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1 && sck == 1'b0 && dq == 4'h0 && ready && !done, "R1",
              {cs_n, sck, dq, ready, done}, 8'b10000010);

        // R2: idle chip-select level follows input, clock stays low
        idle_cs_lvl = 1'b0;
        @(negedge clk);
        check(cs_n == 1'b0, "R2", cs_n, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(sck == 1'b0 && ready == 1'b1, "R2", {sck, ready}, 2'b01);
        end
        idle_cs_lvl = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1, "R2", cs_n, 1);

        // Directed corners
        run_xfer(2'b00, 5, 1'b1, 1'b0, "R4");
        run_xfer(2'b01, 0, 1'b1, 1'b0, "R5");
        run_xfer(2'b10, 0, 1'b1, 1'b0, "R10");
        run_xfer(2'b11, 0, 1'b0, 1'b0, "R10");
        run_xfer(2'b10, 1, 1'b1, 1'b0, "R6");
        run_xfer(2'b11, 3, 1'b1, 1'b0, "R7");
        run_xfer(2'b11, 70, 1'b1, 1'b0, "R8");
        run_xfer(2'b10, 68, 1'b0, 1'b0, "R8");
        run_xfer(2'b10, 5, 1'b1, 1'b1, "R12");
        run_xfer(2'b11, 2047, 1'b1, 1'b0, "R8");

        // Random frames
        for (int t = 0; t < 16; t++) begin
            logic [1:0] m;
            m = 2'($urandom);
            case (m)
                2'b00:   run_xfer(m, $urandom_range(0, 80), 1'($urandom), 1'b0, "R4");
                2'b01:   run_xfer(m, $urandom_range(0, 80), 1'($urandom), 1'b0, "R5");
                2'b10:   run_xfer(m, $urandom_range(0, 80), 1'($urandom), 1'b0, "R6");
                default: run_xfer(m, $urandom_range(0, 80), 1'($urandom), 1'b0, "R7");
            endcase
        end
        idle_cs_lvl = 1'b1;
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule